// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a system watchdog. A fixed prescaler divides a slow timing tick into a counting tick. A down-counter reloads from a programmed timeout value. When the counter expires while the watchdog is enabled, the block raises a reset request for a fixed number of clock cycles. Software prevents that reset by issuing a restart command before the counter reaches the end of its period.

When reset ends, the watchdog is already enabled and running with the longest possible timeout, so a program that hangs during boot is still caught. The mode register takes one write after reset. That write can set a new timeout, or it can turn the watchdog off. From then on the register is locked, and further writes have no effect until the next reset. Status outputs show whether the watchdog is enabled, whether the mode is locked, and whether a watchdog reset request has occurred.

The slow tick is a single-cycle enable in the `clk_i` domain. With the default parameters (12-bit counter, divide by 128, 256 Hz counting tick), the longest timeout is 4096 counting ticks, which is 16 seconds.

Top module: `wdt_top`

## Requirements
- R1: After reset, `enabled_o` is 1, `locked_o` is 0, `wdt_rst_o` is 0 and `fired_o` is 0.
- R2: The counter moves only on a counting tick, which occurs once every PRESC_DIV cycles in which `slow_tick_i` is 1. While `slow_tick_i` is 0 the watchdog makes no progress.
- R3: With timeout value V loaded at a clock edge and `slow_tick_i` held at 1, `wdt_rst_o` first reads 1 after exactly PRESC_DIV*(V+1) further clock edges.
- R4: After reset release, with no mode write, the first reset request follows PRESC_DIV*2^CNT_W slow ticks (the maximum timeout).
- R5: A restart (`kick_i`=1 while enabled) reloads the counter with the timeout value and clears the prescaler. Restarts issued more often than the timeout prevent any reset request.
- R6: The first mode write (`mode_we_i`=1) applies `mode_en_i` and `mode_tmo_i` and restarts the count from the new value.
- R7: Once a mode write has been accepted, `locked_o` reads 1. Later mode writes change neither the enable, nor the timeout, nor the running count.
- R8: With the watchdog disabled by the mode write, no reset request is ever raised and `kick_i` has no effect.
- R9: Each expiry holds `wdt_rst_o` high for exactly RST_HOLD consecutive clock cycles.
- R10: `fired_o` becomes 1 together with the first reset request and stays 1 until `rst_ni` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | Single-cycle slow-clock enable |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_en_i | input | 1 | Enable value for the mode write |
| mode_tmo_i | input | CNT_W | Timeout value for the mode write, in counting ticks minus one |
| kick_i | input | 1 | Restart command |
| wdt_rst_o | output | 1 | Reset request, held for RST_HOLD cycles |
| fired_o | output | 1 | Sticky flag: a watchdog reset request has occurred |
| locked_o | output | 1 | Mode register has been written |
| enabled_o | output | 1 | Watchdog currently enabled |

## Verification
The bench builds the block with CNT_W=4, PRESC_DIV=4 and RST_HOLD=3. With these values all sixteen timeout settings can be swept, and each expiry is only 4 to 64 cycles away, so every timeout is measured to the exact cycle against PRESC_DIV*(V+1). The 64-cycle default timeout can also be reached directly from reset. Because RST_HOLD is shorter than one prescaler period, the pulse width stays measurable even when expiries follow one another closely. The short periods also make long runs of restarts, disabled operation and ignored second writes cheap to cover.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic en;
    logic locked;
  } wdt_flags_t;

  localparam int unsigned WDT_MIN_DIV = 2;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESC_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_tick_i,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  import wdt_pkg::*;
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] presc_q;

  initial begin
    if (PRESC_DIV < WDT_MIN_DIV) $error("PRESC_DIV too small");
  end

  assign tick_o = run_i && slow_tick_i && (presc_q == LAST) && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    presc_q <= '0;
    else if (clear_i)               presc_q <= '0;
    else if (run_i && slow_tick_i)  presc_q <= (presc_q == LAST) ? '0 : presc_q + 1'b1;
  end

  p_tick_needs_slow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> slow_tick_i);
  p_no_slow_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slow_tick_i && !clear_i) |=> $stable(presc_q));
endmodule

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             apply_o,
  output logic             en_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] tmo_o
);
  import wdt_pkg::*;
  wdt_flags_t    flags_q;
  logic [CNT_W-1:0] tmo_q;

  assign apply_o  = we_i && !flags_q.locked;
  assign en_o     = flags_q.en;
  assign locked_o = flags_q.locked;
  assign tmo_o    = tmo_q;

  // reset state: armed, unlocked, max timeout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '{en: 1'b1, locked: 1'b0};
      tmo_q   <= '1;
    end else if (apply_o) begin
      flags_q <= '{en: en_i, locked: 1'b1};
      tmo_q   <= tmo_i;
    end
  end

  p_lock_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  p_mode_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> ($stable(tmo_o) && $stable(en_o)));
  p_write_locks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> locked_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = en_i && tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '1;
    else if (load_i)          cnt_q <= tmo_i;
    else if (en_i && tick_i)  cnt_q <= (cnt_q == '0) ? tmo_i : cnt_q - 1'b1;
  end

  p_no_fire_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !fire_o);
  p_fire_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> tick_i);
  p_load_restarts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(tmo_i)));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned RST_HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o,
  output logic fired_o
);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);
  logic [HW-1:0] hold_q;
  logic          fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      fired_q <= 1'b0;
    end else begin
      if (fire_i)              hold_q <= HW'(RST_HOLD);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      if (fire_i)              fired_q <= 1'b1;
    end
  end

  assign rst_o   = (hold_q != '0);
  assign fired_o = fired_q;

  p_fire_asserts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rst_o);
  p_fired_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_o |=> fired_o);
  p_rst_implies_fired_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> fired_o);
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned PRESC_DIV = 128,
  parameter int unsigned RST_HOLD  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_tick_i,
  input  logic             mode_we_i,
  input  logic             mode_en_i,
  input  logic [CNT_W-1:0] mode_tmo_i,
  input  logic             kick_i,
  output logic             wdt_rst_o,
  output logic             fired_o,
  output logic             locked_o,
  output logic             enabled_o
);
  logic             apply, en, tick, load, fire;
  logic [CNT_W-1:0] tmo;

  wdt_mode_reg #(.CNT_W(CNT_W)) u_mode (
    .clk_i, .rst_ni,
    .we_i(mode_we_i), .en_i(mode_en_i), .tmo_i(mode_tmo_i),
    .apply_o(apply), .en_o(en), .locked_o(locked_o), .tmo_o(tmo)
  );

  // restart only honoured while enabled; an accepted mode write also restarts
  assign load = apply || (kick_i && en);

  wdt_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk_i, .rst_ni, .slow_tick_i,
    .clear_i(load), .run_i(en), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(en),
    .load_i(load), .tmo_i(apply ? mode_tmo_i : tmo), .fire_o(fire)
  );

  wdt_rst_pulse #(.RST_HOLD(RST_HOLD)) u_pulse (
    .clk_i, .rst_ni, .fire_i(fire), .rst_o(wdt_rst_o), .fired_o(fired_o)
  );

  assign enabled_o = en;

  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enabled_o && !wdt_rst_o) |=> !wdt_rst_o);
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int unsigned CW = 4, DIV = 4, HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0, slow = 1'b1, we = 1'b0, men = 1'b0, kick = 1'b0;
  logic [CW-1:0] mtmo = '0;
  logic wrst, fired, locked, enabled;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_top #(.CNT_W(CW), .PRESC_DIV(DIV), .RST_HOLD(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .mode_we_i(we),
    .mode_en_i(men), .mode_tmo_i(mtmo), .kick_i(kick),
    .wdt_rst_o(wrst), .fired_o(fired), .locked_o(locked), .enabled_o(enabled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; kick = 1'b0; slow = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic mode_write(input logic e, input logic [CW-1:0] t);
    we = 1'b1; men = e; mtmo = t;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // edges after the load edge until wdt_rst_o first reads 1 (0 if none)
  task automatic measure(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (wrst) begin n = i; return; end
    end
  endtask

  task automatic width(output int w);
    w = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!wrst) return;
      w++;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    done = 1'b1;
  end

  initial begin
    int n, w;
    bit any;
    // R1 reset state, R4 default timeout
    do_reset(1'b1);
    chk(enabled == 1'b1, "R1", enabled, 1);
    chk(locked == 1'b0, "R1", locked, 0);
    chk(wrst == 1'b0, "R1", wrst, 0);
    chk(fired == 1'b0, "R1", fired, 0);
    measure(200, n);
    chk(n == DIV * (1 << CW), "R4", n, DIV * (1 << CW));
    chk(fired == 1'b1, "R10", fired, 1);

    // R3 / R6 / R9: sweep all timeout values
    for (int v = 0; v < (1 << CW); v++) begin
      do_reset(1'b1);
      mode_write(1'b1, CW'(v));
      chk(locked == 1'b1, "R7", locked, 1);
      chk(fired == 1'b0, "R10", fired, 0);
      measure(200, n);
      chk(n == DIV * (v + 1), "R3", n, DIV * (v + 1));
      if (v >= 1) begin
        width(w);
        chk(w == HOLD, "R9", w, HOLD);
        chk(fired == 1'b1, "R10", fired, 1);
      end
    end

    // R7: second write ignored, does not restart count
    do_reset(1'b1);
    mode_write(1'b1, CW'(9));
    repeat (10) @(negedge clk);
    mode_write(1'b1, CW'(2));
    measure(200, n);
    chk(n + 11 == DIV * 10, "R7", n + 11, DIV * 10);

    // R5: periodic restarts keep it quiet, then expiry after last restart
    do_reset(1'b1);
    mode_write(1'b1, CW'(3));
    any = 1'b0;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < 9; j++) begin
        @(negedge clk);
        if (wrst) any = 1'b1;
      end
      do_kick();
    end
    chk(!any, "R5", any, 0);
    measure(200, n);
    chk(n == DIV * 4, "R5", n, DIV * 4);

    // R8: disabled, kicks and later writes have no effect
    do_reset(1'b1);
    mode_write(1'b0, CW'(0));
    chk(enabled == 1'b0, "R8", enabled, 0);
    any = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (k % 50 == 7) do_kick(); else @(negedge clk);
      if (k == 100) mode_write(1'b1, CW'(0));
      if (wrst) any = 1'b1;
    end
    chk(!any, "R8", any, 0);
    chk(fired == 1'b0, "R8", fired, 0);
    chk(enabled == 1'b0, "R7", enabled, 0);

    // R2: no slow ticks, no progress
    do_reset(1'b0);
    any = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (wrst) any = 1'b1;
    end
    chk(!any, "R2", any, 0);
    slow = 1'b1;
    measure(200, n);
    chk(n == DIV * (1 << CW), "R2", n, DIV * (1 << CW));

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule